// File: doc/BRIEF.md
# Early-Wakeup Issue Window

This block is the scheduling window of an out-of-order core for single-cycle operations. Decoded instructions enter one per cycle with two source operands. Each operand is either already resolved, with its value, or waiting on the destination tag of a producer that has not issued yet. Every cycle the window picks the oldest entry whose operands are both resolved and sends it to a single-cycle functional unit. The picked instruction's destination tag goes out to all waiting entries in that same cycle, one cycle before its result exists.

A waiting entry that matches the announced tag counts as ready at the next clock edge. It may therefore issue in the very next cycle, directly behind its producer. For each operand woken this way, a per-operand bypass flag steers the issue operand mux to take the functional unit output instead of a stored value. This lets a chain of dependent operations issue on consecutive cycles. If a woken entry is not picked in that next cycle, it copies the result into its value field and clears the flag.

Top module: `early_wake_issue`

## Requirements
- R1: After synchronous reset the window is empty: `iss_valid`, `res_valid` and `win_full` are all low.
- R2: An instruction dispatched with both operands resolved issues in the cycle after dispatch, with the dispatched values on `iss_a`/`iss_b` and `iss_byp` equal to 2'b00.
- R3: At most one instruction issues per cycle, and among ready entries the one dispatched earliest is chosen, whatever slot it occupies.
- R4: An entry whose operand waits on tag T issues in the cycle right after the producer with `iss_dst` = T issued. The bypass bit for that operand is set (bit 0 for the first source, bit 1 for the second), and the operand equals the producer's result.
- R5: In the cycle after an issue, `res_valid` is high, `res_tag` equals the issued `iss_dst`, and `res_data` is the 16-bit wrapped result of the issued operation on `iss_a`/`iss_b`. The operation codes are 0 add, 1 subtract (a minus b), 2 bitwise and, 3 bitwise xor.
- R6: An entry woken by a tag but not chosen in the following cycle keeps the producer's result. It later issues with its bypass bit clear and that value on the operand.
- R7: At dispatch, an unresolved operand whose tag equals the tag issuing in that same cycle is woken for bypass. One whose tag equals `res_tag` while `res_valid` is high takes `res_data` as its value.
- R8: With all 8 entries occupied, `win_full` is high and a dispatch in that cycle is dropped, so it never issues.
- R9: When both operands wait on the same producer, both bypass bits are set and both operands equal that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_op | input | 2 | Operation code of the dispatched instruction |
| disp_dst | input | 6 | Destination tag of the dispatched instruction |
| disp_tag0 | input | 6 | First source producer tag |
| disp_rdy0 | input | 1 | First source already resolved |
| disp_val0 | input | 16 | First source value when resolved |
| disp_tag1 | input | 6 | Second source producer tag |
| disp_rdy1 | input | 1 | Second source already resolved |
| disp_val1 | input | 16 | Second source value when resolved |
| win_full | output | 1 | All entries occupied; dispatch is dropped |
| iss_valid | output | 1 | An instruction issues this cycle (also the early tag broadcast) |
| iss_op | output | 2 | Operation code of the issuing instruction |
| iss_dst | output | 6 | Destination tag being issued and broadcast |
| iss_a | output | 16 | First operand after the bypass mux |
| iss_b | output | 16 | Second operand after the bypass mux |
| iss_byp | output | 2 | Per-operand bypass select used this cycle |
| res_valid | output | 1 | Functional unit result valid |
| res_tag | output | 6 | Tag of the functional unit result |
| res_data | output | 16 | Functional unit result value |

## Verification
A corrupted age matrix appears at the issue port in the first cycle that two entries are ready at once: the younger tag comes out first. A bypass flag that is lost or held too long shows up the same cycle on `iss_byp`, and one cycle later as a wrong `res_data`. A missed wakeup looks like an empty issue slot in the cycle right after the producer. A dropped or duplicated allocation shows up as a wrong count of issued tags when a full window drains. The sweep runs every combination of the four operations along a three-deep dependence chain, so each bypassed value is also seen through the arithmetic result.

// File: rtl/iw_pkg.sv
package iw_pkg;

    parameter int unsigned TAG_W  = 6;
    parameter int unsigned DATA_W = 16;
    parameter int unsigned OP_W   = 2;
    parameter int unsigned NSRC   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } op_e;

    // One source operand held in a window slot
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              rdy;
        logic              byp;   // woken by an early tag last cycle
        logic [DATA_W-1:0] val;
    } src_t;

    // Full state of one window slot
    typedef struct packed {
        logic              valid;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  dst;
        src_t [NSRC-1:0]   src;
    } slot_t;

    // Fields a slot exposes to the issue multiplexer
    typedef struct packed {
        logic                        valid;
        logic [OP_W-1:0]             op;
        logic [TAG_W-1:0]            dst;
        logic [NSRC-1:0]             byp;
        logic [NSRC-1:0][DATA_W-1:0] val;
    } issue_t;

    function automatic logic [DATA_W-1:0] alu_eval(
        input logic [OP_W-1:0]   op,
        input logic [DATA_W-1:0] a,
        input logic [DATA_W-1:0] b
    );
        case (op_e'(op))
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            default: return a ^ b;
        endcase
    endfunction

endpackage

// File: rtl/iw_slot.sv
module iw_slot
    import iw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  slot_t             alloc_d,
    input  logic              grant,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output issue_t            view,
    output logic              req
);

    slot_t st;
    slot_t nxt;

    always_comb begin
        nxt = st;
        if (alloc) begin
            nxt       = alloc_d;
            nxt.valid = 1'b1;
            for (int k = 0; k < NSRC; k++) begin
                nxt.src[k].byp = 1'b0;
                if (!alloc_d.src[k].rdy) begin
                    if (bc_valid && bc_tag == alloc_d.src[k].tag) begin
                        nxt.src[k].rdy = 1'b1;
                        nxt.src[k].byp = 1'b1;
                    end else if (res_valid && res_tag == alloc_d.src[k].tag) begin
                        nxt.src[k].rdy = 1'b1;
                        nxt.src[k].val = res_data;
                    end
                end
            end
        end else if (st.valid) begin
            if (grant) begin
                nxt.valid = 1'b0;
            end
            for (int k = 0; k < NSRC; k++) begin
                if (st.src[k].byp) begin
                    // producer result is on the FU output this cycle: keep it
                    nxt.src[k].val = res_data;
                    nxt.src[k].byp = 1'b0;
                end else if (!st.src[k].rdy && bc_valid && bc_tag == st.src[k].tag) begin
                    nxt.src[k].rdy = 1'b1;
                    nxt.src[k].byp = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        req = st.valid;
        for (int k = 0; k < NSRC; k++) begin
            req = req & st.src[k].rdy;
        end
        view.valid = st.valid;
        view.op    = st.op;
        view.dst   = st.dst;
        for (int k = 0; k < NSRC; k++) begin
            view.byp[k] = st.src[k].byp;
            view.val[k] = st.src[k].val;
        end
    end

    // R6: a bypass flag lives for one cycle only, then the value is held
    a_r6_byp_clears_src0: assert property (@(posedge clk) disable iff (rst)
        (st.valid && st.src[0].byp && !grant) |=> !st.src[0].byp);
    a_r6_byp_clears_src1: assert property (@(posedge clk) disable iff (rst)
        (st.valid && st.src[1].byp && !grant) |=> !st.src[1].byp);

endmodule

// File: rtl/iw_age_select.sv
module iw_age_select #(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] alloc,
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] req,
    output logic [DEPTH-1:0] grant
);

    // older[i][j] set: slot j holds an instruction dispatched before slot i
    logic [DEPTH-1:0] older [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                older[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (alloc[i]) begin
                        older[i][j] <= valid[j];
                    end else if (alloc[j]) begin
                        older[i][j] <= 1'b0;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_pick
        assign grant[g] = req[g] && ((req & older[g]) == '0);
    end

    a_r3_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    a_r3_no_idle_when_ready: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (grant != '0));

endmodule

// File: rtl/iw_fu.sv
module iw_fu
    import iw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [DATA_W-1:0] out_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_tag  <= in_tag;
                out_data <= alu_eval(in_op, in_a, in_b);
            end
        end
    end

endmodule

// File: rtl/early_wake_issue.sv
module early_wake_issue
    import iw_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic [TAG_W-1:0]  disp_dst,
    input  logic [TAG_W-1:0]  disp_tag0,
    input  logic              disp_rdy0,
    input  logic [DATA_W-1:0] disp_val0,
    input  logic [TAG_W-1:0]  disp_tag1,
    input  logic              disp_rdy1,
    input  logic [DATA_W-1:0] disp_val1,
    output logic              win_full,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [TAG_W-1:0]  iss_dst,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b,
    output logic [NSRC-1:0]   iss_byp,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [DATA_W-1:0] res_data
);

    slot_t                       disp_word;
    issue_t                      view [DEPTH];
    logic [DEPTH-1:0]            valid_vec;
    logic [DEPTH-1:0]            req_vec;
    logic [DEPTH-1:0]            grant_vec;
    logic [DEPTH-1:0]            alloc_vec;
    logic                        disp_go;
    logic [NSRC-1:0][DATA_W-1:0] sel_val;

    assign win_full = &valid_vec;
    assign disp_go  = disp_valid && !win_full;

    always_comb begin
        disp_word.valid      = 1'b1;
        disp_word.op         = disp_op;
        disp_word.dst        = disp_dst;
        disp_word.src[0].tag = disp_tag0;
        disp_word.src[0].rdy = disp_rdy0;
        disp_word.src[0].byp = 1'b0;
        disp_word.src[0].val = disp_val0;
        disp_word.src[1].tag = disp_tag1;
        disp_word.src[1].rdy = disp_rdy1;
        disp_word.src[1].byp = 1'b0;
        disp_word.src[1].val = disp_val1;
    end

    // lowest-numbered free slot takes the dispatch
    always_comb begin
        logic taken;
        taken     = 1'b0;
        alloc_vec = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_vec[i] && !taken) begin
                alloc_vec[i] = disp_go;
                taken        = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        iw_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc_vec[g]),
            .alloc_d   (disp_word),
            .grant     (grant_vec[g]),
            .bc_valid  (iss_valid),
            .bc_tag    (iss_dst),
            .res_valid (res_valid),
            .res_tag   (res_tag),
            .res_data  (res_data),
            .view      (view[g]),
            .req       (req_vec[g])
        );
        assign valid_vec[g] = view[g].valid;
    end

    iw_age_select #(.DEPTH(DEPTH)) u_select (
        .clk   (clk),
        .rst   (rst),
        .alloc (alloc_vec),
        .valid (valid_vec),
        .req   (req_vec),
        .grant (grant_vec)
    );

    // one-hot AND-OR issue mux; the selected tag doubles as the early broadcast
    always_comb begin
        iss_valid = 1'b0;
        iss_op    = '0;
        iss_dst   = '0;
        iss_byp   = '0;
        sel_val   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant_vec[i]) begin
                iss_valid = iss_valid | view[i].valid;
                iss_op    = iss_op    | view[i].op;
                iss_dst   = iss_dst   | view[i].dst;
                iss_byp   = iss_byp   | view[i].byp;
                sel_val   = sel_val   | view[i].val;
            end
        end
        iss_a = iss_byp[0] ? res_data : sel_val[0];
        iss_b = iss_byp[1] ? res_data : sel_val[1];
    end

    iw_fu u_fu (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (iss_valid),
        .in_op     (iss_op),
        .in_tag    (iss_dst),
        .in_a      (iss_a),
        .in_b      (iss_b),
        .out_valid (res_valid),
        .out_tag   (res_tag),
        .out_data  (res_data)
    );

    // R1: first cycle out of reset is idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!iss_valid && !res_valid && !win_full));
    // R4: a bypass select is only used while the FU output holds a result
    a_r4_bypass_needs_result: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_byp != '0) |-> res_valid);
    // R5: the result follows the issue by exactly one cycle with its tag
    a_r5_result_follows_issue: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> (res_valid && res_tag == $past(iss_dst)));
    a_r5_no_result_without_issue: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |=> !res_valid);
    // R8: a full window stays full until something issues
    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        (win_full && !iss_valid) |=> win_full);

endmodule

// File: tb/early_wake_issue_test.sv
module early_wake_issue_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_valid = 1'b0;
    logic [1:0]  disp_op = '0;
    logic [5:0]  disp_dst = '0, disp_tag0 = '0, disp_tag1 = '0;
    logic        disp_rdy0 = 1'b0, disp_rdy1 = 1'b0;
    logic [15:0] disp_val0 = '0, disp_val1 = '0;
    logic        win_full, iss_valid, res_valid;
    logic [1:0]  iss_op, iss_byp;
    logic [5:0]  iss_dst, res_tag;
    logic [15:0] iss_a, iss_b, res_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    early_wake_issue uut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_tag0(disp_tag0), .disp_rdy0(disp_rdy0), .disp_val0(disp_val0),
        .disp_tag1(disp_tag1), .disp_rdy1(disp_rdy1), .disp_val1(disp_val1),
        .win_full(win_full), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b), .iss_byp(iss_byp),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] model_op(input int op, input logic [15:0] a, input logic [15:0] b);
        if (op == 0) return a + b;
        if (op == 1) return a - b;
        if (op == 2) return a & b;
        return a ^ b;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic disp(input int op, input int dst,
                        input int t0, input bit r0, input int v0,
                        input int t1, input bit r1, input int v1);
        disp_valid = 1'b1;
        disp_op    = 2'(op);
        disp_dst   = 6'(dst);
        disp_tag0  = 6'(t0);
        disp_rdy0  = r0;
        disp_val0  = 16'(v0);
        disp_tag1  = 6'(t1);
        disp_rdy1  = r1;
        disp_val1  = 16'(v1);
        tick();
        disp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] pa, pb, cb, p, r1v, r2v;
        tick();
        tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1", "iss_valid", 32'(iss_valid), 0);
        chk("R1", "res_valid", 32'(res_valid), 0);
        chk("R1", "win_full", 32'(win_full), 0);

        // Age order and resolved dispatch: R2, R3, R4, R6
        disp(0, 20, 0, 1, 1, 0, 1, 2);
        chk("R2", "iss_dst", 32'(iss_dst), 20);
        chk("R2", "iss_a", 32'(iss_a), 1);
        chk("R2", "iss_b", 32'(iss_b), 2);
        chk("R2", "iss_byp", 32'(iss_byp), 0);
        disp(0, 21, 50, 0, 0, 0, 1, 100);
        chk("R3", "iss_valid waiting", 32'(iss_valid), 0);
        disp(1, 22, 50, 0, 0, 0, 1, 5);
        disp(0, 50, 0, 1, 30, 0, 1, 40);
        chk("R4", "producer dst", 32'(iss_dst), 50);
        tick();
        chk("R3", "older consumer first", 32'(iss_dst), 21);
        chk("R4", "iss_byp", 32'(iss_byp), 1);
        chk("R4", "iss_a bypassed", 32'(iss_a), 70);
        chk("R4", "iss_b", 32'(iss_b), 100);
        tick();
        chk("R6", "delayed dst", 32'(iss_dst), 22);
        chk("R6", "iss_byp", 32'(iss_byp), 0);
        chk("R6", "iss_a held", 32'(iss_a), 70);
        chk("R5", "res_data add", 32'(res_data), 170);
        tick();
        chk("R5", "res_data sub", 32'(res_data), 65);
        chk("R5", "res_tag", 32'(res_tag), 22);
        tick();

        // R7 dispatch-time wakeups
        disp(0, 60, 0, 1, 9, 0, 1, 4);
        disp(0, 61, 60, 0, 0, 0, 1, 1);
        chk("R7", "bcast match dst", 32'(iss_dst), 61);
        chk("R7", "bcast match byp", 32'(iss_byp), 1);
        chk("R7", "bcast match a", 32'(iss_a), 13);
        tick();
        disp(3, 62, 0, 1, 16'hF0, 0, 1, 16'h0F);
        tick();
        chk("R7", "res_tag before capture", 32'(res_tag), 62);
        disp(1, 63, 62, 0, 0, 0, 1, 16'h10);
        chk("R7", "res match dst", 32'(iss_dst), 63);
        chk("R7", "res match byp", 32'(iss_byp), 0);
        chk("R7", "res match a", 32'(iss_a), 16'hFF);
        tick();
        chk("R5", "res_data after res capture", 32'(res_data), 16'hEF);
        tick();

        // R8 full window, dropped dispatch, drain in age order
        for (int k = 1; k <= 7; k++) begin
            disp(0, 70 - 64 + k, 5, 0, 0, 0, 1, k);
        end
        chk("R8", "win_full at 7", 32'(win_full), 0);
        disp(0, 5, 0, 1, 50, 0, 1, 0);
        chk("R8", "win_full at 8", 32'(win_full), 1);
        chk("R8", "producer issues", 32'(iss_dst), 5);
        disp(0, 40, 0, 1, 1, 0, 1, 1);
        chk("R8", "first consumer dst", 32'(iss_dst), 7);
        chk("R4", "first consumer byp", 32'(iss_byp), 1);
        chk("R4", "first consumer a", 32'(iss_a), 50);
        for (int k = 2; k <= 7; k++) begin
            tick();
            chk("R3", "drain order", 32'(iss_dst), 6 + k);
            chk("R6", "captured a", 32'(iss_a), 50);
            chk("R6", "captured b", 32'(iss_b), k);
            chk("R6", "byp clear", 32'(iss_byp), 0);
        end
        tick();
        chk("R8", "dropped never issues", 32'(iss_valid), 0);
        chk("R8", "win_full cleared", 32'(win_full), 0);
        tick();

        // Sweep: every op along a three-deep chain: R4, R5, R9
        for (int base = 3; base < 400; base += 197) begin
            for (int o0 = 0; o0 < 4; o0++) begin
                for (int o1 = 0; o1 < 4; o1++) begin
                    for (int o2 = 0; o2 < 4; o2++) begin
                        pa  = 16'(base * 37 + o0);
                        pb  = 16'(base * 3 + 1);
                        cb  = 16'(base + 17 * o1);
                        p   = model_op(o0, pa, pb);
                        r1v = model_op(o1, p, cb);
                        r2v = model_op(o2, r1v, r1v);
                        disp(o1, 2, 1, 0, 0, 0, 1, cb);
                        disp(o2, 3, 2, 0, 0, 2, 0, 0);
                        disp(o0, 1, 0, 1, pa, 0, 1, pb);
                        chk("R4", "chain head dst", 32'(iss_dst), 1);
                        tick();
                        chk("R4", "link1 dst", 32'(iss_dst), 2);
                        chk("R4", "link1 byp", 32'(iss_byp), 1);
                        chk("R4", "link1 a", 32'(iss_a), 32'(p));
                        chk("R5", "head result", 32'(res_data), 32'(p));
                        tick();
                        chk("R9", "link2 dst", 32'(iss_dst), 3);
                        chk("R9", "link2 byp", 32'(iss_byp), 3);
                        chk("R9", "link2 a", 32'(iss_a), 32'(r1v));
                        chk("R9", "link2 b", 32'(iss_b), 32'(r1v));
                        tick();
                        chk("R5", "tail result", 32'(res_data), 32'(r2v));
                        chk("R5", "tail tag", 32'(res_tag), 3);
                        tick();
                    end
                end
            end
        end
        finish_run();
    end

endmodule